// File: doc/BRIEF.md
# Hobby Servo Pulse Generator

This block drives the control pin of a position servo. A commanded angle from 0 to 180 degrees is written through a single write strobe with an 8-bit data bus. Each frame, the block sends one high pulse whose length grows linearly with the angle. The frame timer and the pulse length are counted in ticks of a one-microsecond enable input, so the system clock can run at any rate above that. A servo keeps its commanded position only while it receives pulses, so the pulse is sent again in every frame, with or without a new write.

The calibration does not use the common 1 to 2 ms span. The shortest pulse is 388 us, the neutral pulse is 1264 us and the longest is 2140 us, and the angles in between are placed on that line with rounding to the nearest microsecond. A written angle is held pending and takes effect only at the boundary of the next frame. This means a pulse already on the pin is never cut short or made longer.

Top module: `servo_pwm_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first tick arrives, `pulse_out` is low. With no write, the commanded angle after reset is 90 degrees, so the first pulse lasts 1264 ticks.
- R2: The distance from one rising edge of `pulse_out` to the next is FRAME_US ticks (20000 by default, 50 Hz). Pulses keep repeating with no new write.
- R3: For an angle a in 0..180, the pulse width in ticks is 388 + floor((a*1752 + 90) / 180). This gives 388 at 0, 1264 at 90, 2140 at 180, 398 at 1, 826 at 45 and 2130 at 179.
- R4: A written angle above 180, up to 255, is treated as 180 and gives a 2140-tick pulse.
- R5: A new angle takes effect only at the next frame boundary. A write made while a pulse is high does not change that pulse. Of several writes within one frame, the last one sets the next pulse.
- R6: The block advances only on clock edges where `tick_us` is high. The pulse width and the frame length are counted in ticks, whatever the spacing between ticks, and the output holds its level while ticks are absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-microsecond time-base enable, one clock wide |
| wr_en | input | 1 | Write strobe for the angle |
| wr_angle | input | 8 | Angle in degrees; values above 180 saturate |
| pulse_out | output | 1 | Servo control pulse, registered |

## Verification
If the frame counter is corrupted, the result shows at the next rising edge of `pulse_out`: the frame comes out longer or shorter, or the pulse never appears. The bench therefore times complete rise-to-rise periods in ticks. An error in the width register or in the angle mapping shows up in the very next pulse, because the length of that pulse differs from the computed value by at least one tick. A pending angle captured at the wrong moment makes the pulse that is already running change length, or makes the following pulse carry a value that was written earlier than the last write. The bench detects this by measuring both pulses around each write.

// File: rtl/servo_pkg.sv
package servo_pkg;
   typedef enum logic {
      RND_NEAREST = 1'b0,
      RND_TRUNC   = 1'b1
   } round_e;
endpackage

// File: rtl/servo_angle_reg.sv
module servo_angle_reg #(
   parameter int ANGLE_W     = 8,
   parameter int MAX_ANGLE   = 180,
   parameter int RESET_ANGLE = 90
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ANGLE_W-1:0] wr_data,
   output logic [ANGLE_W-1:0] angle_q
);
   localparam logic [ANGLE_W-1:0] MAX_V = ANGLE_W'(MAX_ANGLE);
   localparam logic [ANGLE_W-1:0] RST_V = ANGLE_W'(RESET_ANGLE);

   if (MAX_ANGLE >= (1 << ANGLE_W)) begin : g_bad_max
      $error("servo_angle_reg: MAX_ANGLE does not fit ANGLE_W");
   end
   if (RESET_ANGLE > MAX_ANGLE) begin : g_bad_rst
      $error("servo_angle_reg: RESET_ANGLE exceeds MAX_ANGLE");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         angle_q <= RST_V;
      end else if (wr_en) begin
         angle_q <= (wr_data > MAX_V) ? MAX_V : wr_data;
      end
   end

   // R4: the pending angle never leaves the legal range
   a_r4_angle_saturated : assert property (@(posedge clk) disable iff (!rst_n)
      angle_q <= MAX_V);
   // R5: pending angle changes only through a write
   a_r5_pending_on_write : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(angle_q));
endmodule

// File: rtl/servo_width_map.sv
module servo_width_map
   import servo_pkg::*;
#(
   parameter int     ANGLE_W   = 8,
   parameter int     MAX_ANGLE = 180,
   parameter int     MIN_US    = 388,
   parameter int     SPAN_US   = 1752,
   parameter int     OUT_W     = 15,
   parameter round_e RMODE     = RND_NEAREST
) (
   input  logic [ANGLE_W-1:0] angle,
   output logic [OUT_W-1:0]   width_us
);
   localparam int PROD_W = ANGLE_W + $clog2(SPAN_US + 1) + 1;

   if (MAX_ANGLE < 1) begin : g_bad_div
      $error("servo_width_map: MAX_ANGLE must be positive");
   end
   if ((MIN_US + SPAN_US) >= (1 << OUT_W)) begin : g_bad_w
      $error("servo_width_map: OUT_W too narrow for the longest pulse");
   end

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] biased;
   logic [PROD_W-1:0] quot;

   assign prod = PROD_W'(angle) * PROD_W'(SPAN_US);

   if (RMODE == RND_NEAREST) begin : g_round
      assign biased = prod + PROD_W'(MAX_ANGLE / 2);
   end else begin : g_trunc
      assign biased = prod;
   end

   assign quot     = biased / PROD_W'(MAX_ANGLE);
   assign width_us = OUT_W'(quot) + OUT_W'(MIN_US);
endmodule

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
   parameter int FRAME_TICKS = 20000,
   parameter int CNT_W       = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             running_q,
   output logic             frame_start
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

   if (FRAME_TICKS > (1 << CNT_W)) begin : g_bad_cnt
      $error("servo_frame_timer: CNT_W too narrow for FRAME_TICKS");
   end

   assign frame_start = tick && (!running_q || (cnt_q == LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
      end else if (tick) begin
         running_q <= 1'b1;
         cnt_q     <= frame_start ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: the position counter stays inside one frame
   a_r2_cnt_in_frame : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   // R6: without a tick, time stands still
   a_r6_hold_without_tick : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(cnt_q) && $stable(running_q)));
   // R1: the counter sits at zero until the first tick after reset
   a_r1_idle_at_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !running_q |-> (cnt_q == '0));
endmodule

// File: rtl/servo_pwm_gen.sv
module servo_pwm_gen
   import servo_pkg::*;
#(
   parameter int     ANGLE_W     = 8,
   parameter int     MAX_ANGLE   = 180,
   parameter int     RESET_ANGLE = 90,
   parameter int     MIN_US      = 388,
   parameter int     SPAN_US     = 1752,
   parameter int     FRAME_US    = 20000,
   parameter round_e RMODE       = RND_NEAREST
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_us,
   input  logic               wr_en,
   input  logic [ANGLE_W-1:0] wr_angle,
   output logic               pulse_out
);
   localparam int CNT_W  = $clog2(FRAME_US);
   localparam int MAX_US = MIN_US + SPAN_US;

   if (MAX_US >= FRAME_US) begin : g_bad_frame
      $error("servo_pwm_gen: longest pulse must be shorter than the frame");
   end

   logic [ANGLE_W-1:0] pend_angle;
   logic [CNT_W-1:0]   next_width;
   logic [CNT_W-1:0]   width_q;
   logic [CNT_W-1:0]   cnt;
   logic               running;
   logic               frame_start;
   logic               pulse_q;

   servo_angle_reg #(
      .ANGLE_W     (ANGLE_W),
      .MAX_ANGLE   (MAX_ANGLE),
      .RESET_ANGLE (RESET_ANGLE)
   ) u_angle (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_angle),
      .angle_q (pend_angle)
   );

   servo_width_map #(
      .ANGLE_W   (ANGLE_W),
      .MAX_ANGLE (MAX_ANGLE),
      .MIN_US    (MIN_US),
      .SPAN_US   (SPAN_US),
      .OUT_W     (CNT_W),
      .RMODE     (RMODE)
   ) u_map (
      .angle    (pend_angle),
      .width_us (next_width)
   );

   servo_frame_timer #(
      .FRAME_TICKS (FRAME_US),
      .CNT_W       (CNT_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_us),
      .cnt_q       (cnt),
      .running_q   (running),
      .frame_start (frame_start)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_q <= CNT_W'(MIN_US);
         pulse_q <= 1'b0;
      end else begin
         if (frame_start) width_q <= next_width;
         pulse_q <= running && (cnt < width_q);
      end
   end

   assign pulse_out = pulse_q;

   // R5: the active width is frozen between frame boundaries
   a_r5_width_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(width_q));
   // R3: the active width lies on the calibrated line
   a_r3_width_range : assert property (@(posedge clk) disable iff (!rst_n)
      (width_q >= CNT_W'(MIN_US)) && (width_q <= CNT_W'(MAX_US)));
   // R1: no pulse before the first frame has begun
   a_r1_low_before_start : assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !pulse_out);
   // R2: the end of every frame is low
   a_r2_low_at_frame_end : assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == CNT_W'(FRAME_US - 1)) |-> !pulse_out);
endmodule

// File: tb/servo_pwm_gen_bench.sv
module servo_pwm_gen_bench;
   localparam int FRAME = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_us = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_angle = 8'd0;
   logic       pulse_out;

   logic tick_en = 1'b0;
   int   tick_every = 1;
   int   tick_div = 0;

   int n_checks = 0;
   int n_fails  = 0;

   servo_pwm_gen #(.FRAME_US(FRAME)) u_servo_pwm_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_us   (tick_us),
      .wr_en     (wr_en),
      .wr_angle  (wr_angle),
      .pulse_out (pulse_out)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!tick_en) begin
         tick_us  <= 1'b0;
         tick_div <= 0;
      end else begin
         tick_us  <= (tick_div == 0);
         tick_div <= (tick_div + 1 >= tick_every) ? 0 : tick_div + 1;
      end
   end

   function automatic int exp_width(input int a);
      int s;
      s = (a > 180) ? 180 : a;
      return 388 + (s * 1752 + 90) / 180;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_rise();
      @(negedge clk);
      while (pulse_out) @(negedge clk);
      while (!pulse_out) @(negedge clk);
   endtask

   // from a fresh rising edge, count ticks while high; returns after the fall
   task automatic measure_width(output int w);
      w = 0;
      wait_rise();
      while (pulse_out) begin
         if (tick_us) w++;
         @(negedge clk);
      end
   endtask

   task automatic measure_period(output int p);
      p = 0;
      wait_rise();
      do begin
         if (tick_us) p++;
         @(negedge clk);
      end while (!(pulse_out && p > 0 && !$isunknown(pulse_out) && prev_low));
   endtask

   logic prev_low = 1'b1;
   always @(negedge clk) prev_low <= !pulse_out;

   task automatic write_angle(input int a);
      @(negedge clk);
      wr_en    = 1'b1;
      wr_angle = 8'(a);
      @(negedge clk);
      wr_en    = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R1 low in reset", int'(pulse_out), 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      check("R1 low before first tick", int'(pulse_out), 0);
   endtask

   task automatic t_first_frame();
      int w, p;
      tick_every = 1;
      tick_en = 1'b1;
      measure_width(w);
      check("R1 first pulse at 90 deg", w, 1264);
      measure_period(p);
      check("R2 frame period", p, FRAME);
      measure_period(p);
      check("R2 repeat without write", p, FRAME);
   endtask

   task automatic t_angle(input int a, input string req);
      int w;
      measure_width(w);
      write_angle(a);
      measure_width(w);
      check(req, w, exp_width(a));
   endtask

   task automatic t_mid_pulse();
      int w;
      measure_width(w);
      write_angle(0);
      measure_width(w);
      check("R5 setup 0 deg", w, 388);
      wait_rise();
      repeat (100) @(negedge clk);
      wr_en = 1'b1; wr_angle = 8'd180;
      @(negedge clk);
      wr_en = 1'b0;
      w = 101;
      while (pulse_out) begin
         if (tick_us) w++;
         @(negedge clk);
      end
      check("R5 running pulse unchanged", w, 388);
      measure_width(w);
      check("R5 new angle next frame", w, 2140);
   endtask

   task automatic t_last_write();
      int w;
      measure_width(w);
      write_angle(10);
      write_angle(150);
      write_angle(45);
      measure_width(w);
      check("R5 last write wins", w, 826);
   endtask

   task automatic t_sparse_ticks();
      int w, p;
      tick_every = 3;
      measure_width(w);
      write_angle(120);
      measure_width(w);
      check("R6 width with sparse ticks", w, exp_width(120));
      measure_period(p);
      check("R6 period with sparse ticks", p, FRAME);
      wait_rise();
      tick_en = 1'b0;
      repeat (200) @(negedge clk);
      check("R6 level held without ticks", int'(pulse_out), 1);
      tick_en = 1'b1;
      w = 0;
      while (pulse_out) begin
         if (tick_us) w++;
         @(negedge clk);
      end
      check("R6 width after tick pause", w, exp_width(120));
   endtask

   initial begin
      t_reset();
      t_first_frame();
      t_angle(0,   "R3 0 deg");
      t_angle(180, "R3 180 deg");
      t_angle(90,  "R3 90 deg");
      t_angle(1,   "R3 1 deg");
      t_angle(45,  "R3 45 deg");
      t_angle(179, "R3 179 deg");
      t_angle(200, "R4 200 saturates");
      t_angle(255, "R4 255 saturates");
      t_angle(181, "R4 181 saturates");
      t_mid_pulse();
      t_last_write();
      t_sparse_ticks();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule